// File: doc/BRIEF.md
# Two-Wire Bus Start Detector with Clock Hold

This block watches the clock (SCL) and data (SDA) lines of a two-wire serial bus and recognises a start condition: the data line falling while the clock line is high. The recognition is made by a flip-flop clocked by the data line itself. It needs no system clock, so the block can raise a wake-up request while the core clock is stopped, and a sleeping slave can then answer the transfer that woke it.

Once the system clock runs, the asynchronous hit passes through a two-stage synchronizer and sets a sticky start flag. Software clears the flag with a one-cycle strobe. In the clock-holding two-wire mode, the block also drives an enable that pulls SCL low from the moment the start is seen. It lets go once the slave reports that it is ready, or when the flag is cleared. The pad delay on SDA and the open-drain drivers lie outside the block.

Top module: `twi_start_detect`

## Requirements
- R1: In a two-wire mode (`mode_i[1]`=1), an SDA fall while SCL is high raises `wake_req` at once, with no clock edge needed. `start_flag` rises at the third rising `clk` edge after the fall.
- R2: An SDA rise while SCL is high (a stop) sets nothing. An SDA fall while SCL is low (a data change) also sets nothing.
- R3: In modes 2'b00 and 2'b01 the detector never flags and `wake_req` stays low. Leaving the two-wire modes drops `wake_req` at once.
- R4: `start_flag` stays set until `flag_clr` is sampled high at a rising edge, and it is low after that edge. `wake_req` is also low after that edge.
- R5: If a new detection posts in the same cycle in which `flag_clr` is sampled, the flag stays set.
- R6: With the system clock stopped, a start still raises `wake_req`. When the clock resumes, `start_flag` rises at the third edge.
- R7: `scl_hold` goes high together with `start_flag`, and only in mode 2'b11. In mode 2'b10 it stays low.
- R8: `scl_hold` drops at the second rising edge after `slave_ready` goes high, that is, one clock after the edge that samples the ready.
- R9: `flag_clr` sampled high also releases `scl_hold` at that edge.
- R10: After reset `start_flag`, `wake_req` and `scl_hold` are all low.
- R11: Once cleared, a later start sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (may be stopped) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (already pad-delayed) |
| mode_i | input | 2 | 00 off, 01 three-wire, 10 two-wire, 11 two-wire with SCL hold |
| flag_clr | input | 1 | One-cycle strobe clearing the start flag |
| slave_ready | input | 1 | Slave ready for more data; releases the hold |
| start_flag | output | 1 | Sticky start-detected flag (clock domain) |
| wake_req | output | 1 | Asynchronous wake-up request |
| scl_hold | output | 1 | Enable that pulls SCL low |

## Verification
The assertions check four things on every clock. The flag persists until it is cleared, and a clear without a new detection takes effect. No wake request exists outside the two-wire modes. A rising hold always comes with the flag in the holding mode, and a ready that has been sampled releases the hold. The timing cannot be covered by cycle-local properties, so the bench scenarios show it: the three-edge delay from the SDA fall to the flag, the rejection of stop and data-change edges, set winning over clear, and detection while the clock is stopped.

// File: rtl/twi_start_detect.sv
module twi_start_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] mode_i,
  input  logic       flag_clr,
  input  logic       slave_ready,
  output logic       start_flag,
  output logic       wake_req,
  output logic       scl_hold
);
  localparam int PIPE = SYNC_STAGES + 1;

  logic            hit;
  logic            clr_q;
  logic            ready_q;
  logic [PIPE-1:0] sync_q;
  logic            hit_clr;
  logic            rise;
  logic            hold_mode;

  assign hit_clr   = ~rst_n | clr_q | ~mode_i[1];
  assign hold_mode = (mode_i == 2'b11);
  assign rise      = sync_q[PIPE-2] & ~sync_q[PIPE-1];
  assign wake_req  = hit;

  always_ff @(negedge sda_in or posedge hit_clr) begin
    if (hit_clr)     hit <= 1'b0;
    else if (scl_in) hit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      clr_q      <= 1'b0;
      ready_q    <= 1'b0;
      start_flag <= 1'b0;
      scl_hold   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[PIPE-2:0], hit};
      clr_q   <= flag_clr;
      ready_q <= slave_ready;
      if (rise)          start_flag <= 1'b1;
      else if (flag_clr) start_flag <= 1'b0;
      if (!hold_mode)                scl_hold <= 1'b0;
      else if (rise)                 scl_hold <= 1'b1;
      else if (flag_clr || ready_q)  scl_hold <= 1'b0;
    end
  end

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    start_flag && !flag_clr |=> start_flag);
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !rise |=> !start_flag);
  a_r3_no_wake_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i[1] |-> !wake_req);
  a_r7_hold_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> start_flag && $past(mode_i) == 2'b11);
  a_r8_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && ready_q && !rise |=> !scl_hold);
endmodule

// File: tb/test_twi_start_detect.sv
module test_twi_start_detect;
  logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, flag_clr = 1'b0, slave_ready = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic start_flag, wake_req, scl_hold;
  int errors = 0, checks = 0;
  string cur_req = "R10";

  // behavioural reference state
  int m_hit = 0, m_flag = 0, m_hold = 0, m_rdy = 0;
  int hist[$];

  twi_start_detect i_twi_start_detect (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .mode_i(mode_i),
    .flag_clr(flag_clr), .slave_ready(slave_ready),
    .start_flag(start_flag), .wake_req(wake_req), .scl_hold(scl_hold));

  always begin #2.5; if (clk_en) clk = ~clk; end

  task automatic chk(string req, string what, logic act, int exp);
    checks++;
    if (act !== exp[0]) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hit = 0; m_flag = 0; m_hold = 0; m_rdy = 0;
      hist = '{0, 0, 0};
    end else begin
      int rise;
      rise = hist[1] & ~hist[0];
      hist.pop_front();
      hist.push_back(m_hit);
      if (rise) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (mode_i != 2'b11) m_hold = 0;
      else if (rise) m_hold = 1;
      else if (flag_clr || m_rdy) m_hold = 0;
      m_rdy = slave_ready;
      if (flag_clr || !mode_i[1]) m_hit = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "start_flag", start_flag, m_flag);
    chk(cur_req, "wake_req", wake_req, m_hit);
    chk(cur_req, "scl_hold", scl_hold, m_hold);
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic set_mode(logic [1:0] m);
    mode_i = m; if (!m[1]) m_hit = 0;
  endtask
  task automatic sda_fall;
    #1 sda_in = 1'b0;
    if (scl_in && mode_i[1]) m_hit = 1;
    #0.5;
  endtask
  task automatic to_idle;
    tick(1); scl_in = 1'b0; tick(1); #1 sda_in = 1'b1; tick(1); scl_in = 1'b1; tick(1);
  endtask
  task automatic clear_flag;
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(2);
    chk("R10", "reset flag", start_flag, 0);
    chk("R10", "reset wake", wake_req, 0);
    chk("R10", "reset hold", scl_hold, 0);
    rst_n = 1'b1; tick(2);

    cur_req = "R1"; set_mode(2'b10); tick(2);
    sda_fall();
    chk("R1", "wake immediate", wake_req, 1);
    tick(2); chk("R1", "flag not yet after 2 edges", start_flag, 0);
    tick(1); chk("R1", "flag after 3 edges", start_flag, 1);
    chk("R7", "no hold in mode 10", scl_hold, 0);
    cur_req = "R4"; to_idle(); tick(4);
    chk("R4", "flag sticky", start_flag, 1);
    clear_flag();
    chk("R4", "flag cleared", start_flag, 0);
    chk("R4", "wake cleared", wake_req, 0);
    tick(4);

    cur_req = "R2";
    scl_in = 1'b0; tick(1); #1 sda_in = 1'b0; tick(1); scl_in = 1'b1; tick(1);
    #1 sda_in = 1'b1; tick(5);
    chk("R2", "stop sets nothing", start_flag, 0);
    chk("R2", "data fall with SCL low sets nothing", wake_req, 0);

    cur_req = "R3";
    for (int m = 0; m < 2; m++) begin
      set_mode(m[1:0]); tick(2); sda_fall(); tick(4);
      chk("R3", "no wake off-mode", wake_req, 0);
      chk("R3", "no flag off-mode", start_flag, 0);
      to_idle();
    end
    set_mode(2'b10); tick(2); sda_fall();
    chk("R3", "wake in two-wire", wake_req, 1);
    set_mode(2'b01); #0.5;
    chk("R3", "wake drops leaving mode", wake_req, 0);
    tick(4); to_idle(); clear_flag(); tick(2);

    cur_req = "R7"; set_mode(2'b11); tick(2); sda_fall(); tick(3);
    chk("R7", "hold with flag", scl_hold, 1);
    cur_req = "R8"; to_idle(); tick(2);
    slave_ready = 1'b1; tick(1);
    chk("R8", "hold kept one edge after ready", scl_hold, 1);
    tick(1); chk("R8", "hold released", scl_hold, 0);
    slave_ready = 1'b0; clear_flag(); tick(2);

    cur_req = "R11"; sda_fall(); tick(3);
    chk("R11", "flag set again", start_flag, 1);
    cur_req = "R9"; to_idle();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R9", "clear releases hold", scl_hold, 0);
    tick(3);

    cur_req = "R5"; sda_fall(); tick(2);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R5", "set wins over clear", start_flag, 1);
    tick(3); to_idle(); clear_flag(); tick(2);

    cur_req = "R6"; tick(1); clk_en = 1'b0; #20;
    sda_fall(); #20;
    chk("R6", "wake with clock stopped", wake_req, 1);
    chk("R6", "flag waits for clock", start_flag, 0);
    clk_en = 1'b1;
    tick(2); chk("R6", "flag not after 2 edges", start_flag, 0);
    tick(1); chk("R6", "flag after 3 edges", start_flag, 1);
    to_idle(); clear_flag(); tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule